// File: doc/BRIEF.md
# Saturating-Counter Branch Prediction Buffer

This block keeps a record of recently resolved branches and grades its own guesses. Each resolved branch arrives as one update beat carrying the branch address and whether the branch was actually taken. The block picks a set from the low address bits. It searches that set's ways for an entry tagged with the full address. On a hit it reports the guess held in that entry's saturating counter, says whether the guess matched the outcome, and moves the counter toward the outcome. On a miss it claims a way, chosen by small decrementing usage counters. It then stores the address and seeds the counter one step to the side of the threshold given by the outcome.

Four saturating statistics counters track hits, misses, right guesses and wrong guesses. An enable input stops all activity. The number of sets, ways, prediction states, usage states and the counter widths are parameters. The defaults are 64 sets, 1 way, 2 prediction states and 2 usage states.

The update input is a valid/ready stream. `upd_ready` follows `enable`. A beat is accepted on a rising clock edge where `upd_valid` and `upd_ready` are both high. The block has no internal queue, so it accepts back-to-back beats and each one sees every earlier update. While `enable` is low a sender holding `upd_valid` high simply waits. The result side has no back-pressure: a grading pulse appears once for each accepted beat.

Top module: `brpred_buf`

## Requirements
- R1: The set index is the branch address modulo SETS, where SETS is a power of two. This means the low log2(SETS) address bits select the set.
- R2: A hit needs a way in the indexed set that is valid and whose stored tag equals the whole incoming address. Reset clears every valid bit, so the first beat to any address, including address 0, is a miss.
- R3: On a hit, `res_pred` is 1 when the stored counter is at least PSTATES/2 (predicted taken). `res_correct` is 1 when `res_pred` equals `upd_taken`. On a miss both are 0.
- R4: On a hit the counter goes up by one for a taken branch unless it is at PSTATES-1. It goes down by one for a not-taken branch unless it is at 0.
- R5: On a miss the claimed way gets the new address as its tag. Its counter is set to PSTATES/2-1 for a not-taken branch, or to PSTATES/2 for a taken branch.
- R6: On every accepted beat, each way of the indexed set with a nonzero usage count drops by one. The way that was hit or claimed is then set to USTATES-1.
- R7: The way claimed on a miss is the highest-numbered way whose usage count (before the beat's own update) is below USTATES-1. If no way qualifies, way 0 is claimed.
- R8: `stat_hit` and `stat_miss` count hits and misses. `stat_good` and `stat_bad` count right and wrong guesses, and only on hits.
- R9: Each statistics counter stops at 2^STAT_W-1 and never wraps.
- R10: While `enable` is low, `upd_ready` is low. No beat is accepted, no entry or statistic changes, and no result pulse appears.
- R11: `res_valid` pulses high in the cycle right after an accepted beat, together with that beat's grading. The statistics counters change on the same edge.
- R12: After reset, `res_valid`, `res_hit`, `res_pred`, `res_correct` and all four statistics counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Gates all lookup, update and statistics activity |
| upd_valid | input | 1 | Resolved-branch beat present |
| upd_ready | output | 1 | Beat can be accepted (equals enable) |
| upd_addr | input | ADDR_W | Branch address |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| res_valid | output | 1 | Grading pulse for the previous accepted beat |
| res_hit | output | 1 | The beat's address was found |
| res_pred | output | 1 | Stored guess was taken (hits only) |
| res_correct | output | 1 | Stored guess matched the outcome (hits only) |
| stat_hit | output | STAT_W | Saturating hit count |
| stat_miss | output | STAT_W | Saturating miss count |
| stat_good | output | STAT_W | Saturating right-guess count |
| stat_bad | output | STAT_W | Saturating wrong-guess count |

## Verification
The bench sends address 0 right after reset. A design that used the tag compare alone, without a valid bit, would report a false hit there. Several addresses that share a set are interleaved so that the victim choice and the usage countdown decide which branch survives. A victim rule that picked the lowest way, or judged it after the decrement, would evict the wrong entry and turn later expected hits into misses. Long same-direction runs drive the prediction counters to both ends. Enough beats are sent to pin the narrow statistics counters at their ceiling, which exposes a counter that wraps or one that grades misses. Beats held up while `enable` is low must leave no result pulse and no change in state.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

  // grading of one accepted beat, as returned one cycle later
  typedef struct packed {
    logic hit;
    logic pred;
    logic correct;
  } grade_t;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/brpred_sat_ctr.sv
module brpred_sat_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (bump && count != TOP) count <= count + W'(1);
  end

  // R9: once at the ceiling the count stays there
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == TOP) |-> (count == TOP));
  p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + W'(1)));
endmodule

// File: rtl/brpred_set_array.sv
module brpred_set_array #(
  parameter int unsigned SETS   = 64,
  parameter int unsigned WAYS   = 1,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PW     = 1,
  parameter int unsigned UW     = 1,
  parameter int unsigned UMAX   = 1,
  localparam int unsigned IDX_W = brpred_pkg::bits_for(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        we,
  output logic [WAYS-1:0]             rd_vld,
  output logic [WAYS-1:0][ADDR_W-1:0] rd_tag,
  output logic [WAYS-1:0][PW-1:0]     rd_ctr,
  output logic [WAYS-1:0][UW-1:0]     rd_use,
  input  logic [WAYS-1:0]             wr_vld,
  input  logic [WAYS-1:0][ADDR_W-1:0] wr_tag,
  input  logic [WAYS-1:0][PW-1:0]     wr_ctr,
  input  logic [WAYS-1:0][UW-1:0]     wr_use
);
  logic [WAYS-1:0]             vld_q [SETS];
  logic [WAYS-1:0][ADDR_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][PW-1:0]     ctr_q [SETS];
  logic [WAYS-1:0][UW-1:0]     use_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        tag_q[s] <= '0;
        ctr_q[s] <= '0;
        use_q[s] <= '0;
      end
    end else if (we) begin
      vld_q[idx] <= wr_vld;
      tag_q[idx] <= wr_tag;
      ctr_q[idx] <= wr_ctr;
      use_q[idx] <= wr_use;
    end
  end

  assign rd_vld = vld_q[idx];
  assign rd_tag = tag_q[idx];
  assign rd_ctr = ctr_q[idx];
  assign rd_use = use_q[idx];

  // R6: a stored usage count never exceeds its top state
  for (genvar w = 0; w < WAYS; w++) begin : g_use_chk
    p_use_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (wr_use[w] <= UW'(UMAX)));
  end
endmodule

// File: rtl/brpred_set_update.sv
module brpred_set_update #(
  parameter int unsigned WAYS    = 1,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PSTATES = 2,
  parameter int unsigned USTATES = 2,
  localparam int unsigned PW = brpred_pkg::bits_for(PSTATES),
  localparam int unsigned UW = brpred_pkg::bits_for(USTATES),
  localparam int unsigned WW = brpred_pkg::bits_for(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        act,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        taken,
  input  logic [WAYS-1:0]             rd_vld,
  input  logic [WAYS-1:0][ADDR_W-1:0] rd_tag,
  input  logic [WAYS-1:0][PW-1:0]     rd_ctr,
  input  logic [WAYS-1:0][UW-1:0]     rd_use,
  output logic [WAYS-1:0]             wr_vld,
  output logic [WAYS-1:0][ADDR_W-1:0] wr_tag,
  output logic [WAYS-1:0][PW-1:0]     wr_ctr,
  output logic [WAYS-1:0][UW-1:0]     wr_use,
  output brpred_pkg::grade_t          grade
);
  localparam logic [PW-1:0] HALF    = PW'(PSTATES / 2);
  localparam logic [PW-1:0] CMAX    = PW'(PSTATES - 1);
  localparam logic [PW-1:0] SEED_NT = PW'(PSTATES / 2 - 1);
  localparam logic [UW-1:0] UMAX    = UW'(USTATES - 1);

  logic [WAYS-1:0] match;
  logic            any_hit;
  logic [WW-1:0]   hit_way, vic_way, sel_way;
  logic [PW-1:0]   cur_ctr;

  // R1/R2: full-address compare in every way of the set
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = rd_vld[w] && (rd_tag[w] == addr);
  end
  assign any_hit = |match;

  // R7: highest way below the top usage state, else way 0
  always_comb begin
    hit_way = '0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w])          hit_way = WW'(w);
      if (rd_use[w] < UMAX)  vic_way = WW'(w);
    end
  end

  assign sel_way = any_hit ? hit_way : vic_way;
  assign cur_ctr = rd_ctr[hit_way];

  // R3: grading from the stored counter
  always_comb begin
    grade.hit     = any_hit;
    grade.pred    = any_hit && (cur_ctr >= HALF);
    grade.correct = any_hit && ((cur_ctr >= HALF) == taken);
  end

  // R4/R5/R6: next contents of the whole set
  always_comb begin
    wr_vld = rd_vld;
    wr_tag = rd_tag;
    wr_ctr = rd_ctr;
    for (int w = 0; w < WAYS; w++)
      wr_use[w] = (rd_use[w] != '0) ? rd_use[w] - UW'(1) : '0;
    wr_use[sel_way] = UMAX;
    wr_vld[sel_way] = 1'b1;
    wr_tag[sel_way] = addr;
    if (any_hit) begin
      if (taken && cur_ctr != CMAX)      wr_ctr[sel_way] = cur_ctr + PW'(1);
      else if (!taken && cur_ctr != '0)  wr_ctr[sel_way] = cur_ctr - PW'(1);
    end else begin
      wr_ctr[sel_way] = taken ? HALF : SEED_NT;
    end
  end

  // R2: allocation keeps tags in a set unique
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> $onehot0(match));
  // R4: counter stays inside its state range
  p_ctr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (wr_ctr[sel_way] <= CMAX));
  // R5: a fresh entry sits next to the threshold
  p_seed_near_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !any_hit) |-> (wr_ctr[sel_way] == SEED_NT || wr_ctr[sel_way] == HALF));
endmodule

// File: rtl/brpred_buf.sv
module brpred_buf #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SETS    = 64,
  parameter int unsigned WAYS    = 1,
  parameter int unsigned PSTATES = 2,
  parameter int unsigned USTATES = 2,
  parameter int unsigned STAT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_pred,
  output logic              res_correct,
  output logic [STAT_W-1:0] stat_hit,
  output logic [STAT_W-1:0] stat_miss,
  output logic [STAT_W-1:0] stat_good,
  output logic [STAT_W-1:0] stat_bad
);
  import brpred_pkg::*;

  localparam int unsigned IDX_W = bits_for(SETS);
  localparam int unsigned PW    = bits_for(PSTATES);
  localparam int unsigned UW    = bits_for(USTATES);

  logic                        accept;
  logic [IDX_W-1:0]            idx;
  logic [WAYS-1:0]             rd_vld, wr_vld;
  logic [WAYS-1:0][ADDR_W-1:0] rd_tag, wr_tag;
  logic [WAYS-1:0][PW-1:0]     rd_ctr, wr_ctr;
  logic [WAYS-1:0][UW-1:0]     rd_use, wr_use;
  grade_t                      grade;
  logic [3:0]                  bump;

  assign upd_ready = enable;
  assign accept    = upd_valid && upd_ready;
  assign idx       = upd_addr[IDX_W-1:0];   // R1: modulo a power of two

  brpred_set_array #(
    .SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .PW(PW), .UW(UW),
    .UMAX(USTATES - 1)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .idx(idx), .we(accept),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_ctr(rd_ctr), .rd_use(rd_use),
    .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_ctr(wr_ctr), .wr_use(wr_use)
  );

  brpred_set_update #(
    .WAYS(WAYS), .ADDR_W(ADDR_W), .PSTATES(PSTATES), .USTATES(USTATES)
  ) u_update (
    .clk(clk), .rst_n(rst_n), .act(accept),
    .addr(upd_addr), .taken(upd_taken),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_ctr(rd_ctr), .rd_use(rd_use),
    .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_ctr(wr_ctr), .wr_use(wr_use),
    .grade(grade)
  );

  // R11: one grading pulse per accepted beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_pred    <= 1'b0;
      res_correct <= 1'b0;
    end else begin
      res_valid   <= accept;
      res_hit     <= accept && grade.hit;
      res_pred    <= accept && grade.pred;
      res_correct <= accept && grade.correct;
    end
  end

  // R8: hit, miss, right, wrong
  assign bump[0] = accept && grade.hit;
  assign bump[1] = accept && !grade.hit;
  assign bump[2] = accept && grade.hit && grade.correct;
  assign bump[3] = accept && grade.hit && !grade.correct;

  logic [3:0][STAT_W-1:0] stats;
  for (genvar k = 0; k < 4; k++) begin : g_stat
    brpred_sat_ctr #(.W(STAT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .bump(bump[k]), .count(stats[k])
    );
  end
  assign stat_hit  = stats[0];
  assign stat_miss = stats[1];
  assign stat_good = stats[2];
  assign stat_bad  = stats[3];

  p_result_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && enable) |=> res_valid);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && enable) |=> !res_valid);
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(stat_hit) && $stable(stat_miss)
                 && $stable(stat_good) && $stable(stat_bad)));
  p_grade_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_good != $past(stat_good) || stat_bad != $past(stat_bad))
      |-> (res_valid && res_hit));
  p_miss_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (!res_pred && !res_correct));
endmodule

// File: tb/sim_brpred_buf.sv
module sim_brpred_buf;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NS = 4;
  localparam int NW = 2;
  localparam int NP = 4;
  localparam int NU = 3;
  localparam int SW = 4;
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic upd_valid = 1'b0;
  logic upd_ready;
  logic [AW-1:0] upd_addr = '0;
  logic upd_taken = 1'b0;
  logic res_valid, res_hit, res_pred, res_correct;
  logic [SW-1:0] stat_hit, stat_miss, stat_good, stat_bad;

  always #(CLK_PERIOD / 2) clk = ~clk;

  brpred_buf #(.ADDR_W(AW), .SETS(NS), .WAYS(NW), .PSTATES(NP),
               .USTATES(NU), .STAT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_addr(upd_addr), .upd_taken(upd_taken),
    .res_valid(res_valid), .res_hit(res_hit), .res_pred(res_pred),
    .res_correct(res_correct), .stat_hit(stat_hit), .stat_miss(stat_miss),
    .stat_good(stat_good), .stat_bad(stat_bad)
  );

  typedef struct {
    bit hit, pred, correct;
    int h, m, g, b;
  } exp_t;
  exp_t q[$];

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // reference state from the requirements
  bit          mv [NS][NW];
  logic [AW-1:0] mt [NS][NW];
  int          mc [NS][NW];
  int          mu [NS][NW];
  int          ch = 0, cm = 0, cg = 0, cb = 0;

  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int sat(input int v);
    return (v < SMAX) ? v + 1 : SMAX;   // R9
  endfunction

  task automatic send(input logic [AW-1:0] a, input bit t, input bit en);
    exp_t e;
    int s, hw, vic, sel;
    @(negedge clk);
    enable = en;
    upd_valid = 1'b1;
    upd_addr = a;
    upd_taken = t;
    check("R10", upd_ready, en, "upd_ready");
    if (!en) return;
    s = int'(a) % NS;                       // R1
    hw = -1;
    for (int w = 0; w < NW; w++)
      if (mv[s][w] && mt[s][w] == a) hw = w; // R2
    vic = 0;
    for (int w = 0; w < NW; w++)
      if (mu[s][w] < NU - 1) vic = w;       // R7
    for (int w = 0; w < NW; w++)
      if (mu[s][w] > 0) mu[s][w]--;         // R6
    e.hit = (hw >= 0);
    if (e.hit) begin
      sel = hw;
      e.pred = (mc[s][sel] >= NP / 2);      // R3
      e.correct = (e.pred == t);
      if (t && mc[s][sel] < NP - 1) mc[s][sel]++;   // R4
      else if (!t && mc[s][sel] > 0) mc[s][sel]--;
      ch = sat(ch);
      if (e.correct) cg = sat(cg); else cb = sat(cb);
    end else begin
      sel = vic;
      e.pred = 0;
      e.correct = 0;
      mv[s][sel] = 1;
      mt[s][sel] = a;
      mc[s][sel] = NP / 2 - 1 + int'(t);    // R5
      cm = sat(cm);
    end
    mu[s][sel] = NU - 1;
    e.h = ch; e.m = cm; e.g = cg; e.b = cb;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      upd_valid = 1'b0;
      enable = 1'b1;
    end
  endtask

  // monitor: compare each grading pulse with the queued expectation (R11)
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) begin
        check("R11", 1, 0, "unexpected res_valid");
      end else begin
        exp_t e;
        e = q.pop_front();
        check("R2", res_hit, e.hit, "res_hit");
        check("R3", res_pred, e.pred, "res_pred");
        check("R3", res_correct, e.correct, "res_correct");
        check("R8", stat_hit, e.h, "stat_hit");
        check("R8", stat_miss, e.m, "stat_miss");
        check("R9", stat_good, e.g, "stat_good");
        check("R9", stat_bad, e.b, "stat_bad");
      end
    end
  end

  initial begin : watchdog
    for (int i = 0; i < 50000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mv[s][w] = 0; mt[s][w] = '0; mc[s][w] = 0; mu[s][w] = 0;
      end
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", res_valid, 0, "res_valid");
    check("R12", {res_hit, res_pred, res_correct}, 0, "grade");
    check("R12", stat_hit + stat_miss + stat_good + stat_bad, 0, "stats");
    rst_n = 1'b1;
    idle(1);

    // R2: address 0 misses first, then hits as weakly taken
    send(16'h0000, 1, 1);
    send(16'h0000, 1, 1);
    // R7/R6: three addresses sharing set 0
    send(16'h0004, 0, 1);
    send(16'h0008, 1, 1);
    send(16'h0000, 1, 1);
    send(16'h0004, 0, 1);
    // R4: drive one entry to both ends
    for (int i = 0; i < 5; i++) send(16'h0101, 1, 1);
    for (int i = 0; i < 5; i++) send(16'h0101, 0, 1);
    // R10: held beats while disabled leave no trace
    send(16'h0101, 1, 0);
    send(16'h0202, 1, 0);
    idle(2);
    check("R10", res_valid, 0, "res_valid while disabled");
    send(16'h0101, 1, 1);   // still at the bottom: predicted not taken
    // mixed traffic; pushes the narrow statistics to their ceiling (R9)
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(AW'((lfsr % 11) * 3), lfsr[8] | lfsr[9], (lfsr[4:2] != 3'd0));
      if (lfsr[11] && lfsr[12]) idle(1);
    end
    idle(3);
    check("R11", q.size(), 0, "pending results");
    check("R9", stat_miss, SMAX, "miss count pinned");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule